// File: doc/BRIEF.md
# Per-Load Stride Prefetcher

The block watches the stream of load instructions and learns, for each load, whether it walks memory with a constant step. A small direct-mapped table is indexed by the low bits of the load's program counter, and each slot keeps four things: the rest of the PC as a tag, the address the load touched last time, the step it is assumed to take, and a confidence state. On every load event the block compares the new address with the last address plus the stored step. It then updates the confidence state and, once the load is judged steady, requests a prefetch one step ahead.

The confidence state has four values: `CS_INIT`, `CS_TRANS` (transient), `CS_STEADY` and `CS_NOPRED` (no prediction). The transitions on a correct prediction are:
- init to steady;
- transient to steady;
- steady to steady;
- no-prediction to transient.

The transitions on an incorrect prediction are:
- init to transient, with a new stride;
- transient to no-prediction, with a new stride;
- steady to init, with the stride kept;
- no-prediction to no-prediction, with a new stride.

A load whose tag does not match takes over the slot. The prefetch request is registered and appears on the cycle after the load.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset every table slot is empty, `pf_valid` is 0, and the first load seen by any slot is treated as a tag miss.
- R2: On a tag miss (empty slot or differing tag), the slot is rewritten with the new tag, the load address, a zero stride and state `CS_INIT`, and no prefetch is issued for that load. The slot index is PC bits [IDX_W-1:0] and the tag is the remaining upper PC bits.
- R3: A prediction is correct when the load address equals the stored previous address plus the stored stride, modulo 2^ADDR_W.
- R4: In `CS_INIT`, a correct prediction moves the slot to `CS_STEADY`. An incorrect one moves it to `CS_TRANS` and sets the stride to the load address minus the previous address.
- R5: In `CS_TRANS`, a correct prediction moves the slot to `CS_STEADY`. An incorrect one moves it to `CS_NOPRED` and sets the stride to the new difference.
- R6: In `CS_STEADY`, a correct prediction keeps the slot in `CS_STEADY`. An incorrect one moves it to `CS_INIT` and leaves the stride unchanged.
- R7: In `CS_NOPRED`, a correct prediction moves the slot to `CS_TRANS`. An incorrect one keeps `CS_NOPRED` and sets the stride to the new difference.
- R8: A prefetch is issued only when the slot's state after the update is `CS_STEADY`. `pf_valid` is high for exactly the cycle after the load, and `pf_addr` equals the load address plus the stride, wrapping modulo 2^ADDR_W.
- R9: Every load writes its own address into the previous-address field of its slot, whatever the outcome.
- R10: Loads whose PCs map to different slots do not affect each other. A load with the same index but a different tag evicts the resident entry.
- R11: A cycle with `ld_valid` low issues no prefetch and changes no slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load event is present this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Address accessed by the load |
| pf_valid | output | 1 | Prefetch request valid, one cycle after the load |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
The first pattern is a constant positive stride. It separates the first touch from the step that learns the stride and from the step that confirms it, so the confidence path from init through transient to steady is checked. The second pattern breaks the stride once and then resumes it from the new address, which shows that a steady slot keeps its stride and that the previous address still moves. The third pattern uses irregular gaps to drive a slot into no-prediction and back out through transient. A descending stream checks the negative stride and the address wrap. Two PCs that share an index, and idle gaps, show eviction, slot independence and that an idle cycle does nothing.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

    typedef enum logic [1:0] {
        CS_INIT   = 2'd0,
        CS_TRANS  = 2'd1,
        CS_STEADY = 2'd2,
        CS_NOPRED = 2'd3
    } conf_state_e;

endpackage

// File: rtl/stride_pf_table.sv
module stride_pf_table
    import stride_pf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 28,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_prev,
    input  logic [ADDR_W-1:0] wr_stride,
    input  conf_state_e       wr_state,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_prev,
    output logic [ADDR_W-1:0] rd_stride,
    output conf_state_e       rd_state
);

    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q    [SLOTS];
    logic [ADDR_W-1:0] prev_q   [SLOTS];
    logic [ADDR_W-1:0] stride_q [SLOTS];
    conf_state_e       state_q  [SLOTS];

    // Occupancy flags are the only reset state; payload is qualified by them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (wr_en && (idx == IDX_W'(s))) begin
                    tag_q[s]    <= wr_tag;
                    prev_q[s]   <= wr_prev;
                    stride_q[s] <= wr_stride;
                    state_q[s]  <= wr_state;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_valid  = valid_q[idx];
        rd_tag    = tag_q[idx];
        rd_prev   = prev_q[idx];
        rd_stride = stride_q[idx];
        rd_state  = state_q[idx];
    end

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0)); // R1

endmodule

// File: rtl/stride_pf_fsm.sv
module stride_pf_fsm
    import stride_pf_pkg::*;
(
    input  conf_state_e cur_state,
    input  logic        correct,
    output conf_state_e nxt_state,
    output logic        take_new_stride
);

    always_comb begin
        nxt_state       = cur_state;
        take_new_stride = 1'b0;
        unique case (cur_state)
            CS_INIT: begin
                if (correct) begin
                    nxt_state = CS_STEADY;
                end else begin
                    nxt_state       = CS_TRANS;
                    take_new_stride = 1'b1;
                end
            end
            CS_TRANS: begin
                if (correct) begin
                    nxt_state = CS_STEADY;
                end else begin
                    nxt_state       = CS_NOPRED;
                    take_new_stride = 1'b1;
                end
            end
            CS_STEADY: begin
                nxt_state = correct ? CS_STEADY : CS_INIT;
            end
            CS_NOPRED: begin
                if (correct) begin
                    nxt_state = CS_TRANS;
                end else begin
                    nxt_state       = CS_NOPRED;
                    take_new_stride = 1'b1;
                end
            end
            default: begin
                nxt_state = CS_INIT;
            end
        endcase
    end

endmodule

// File: rtl/stride_pf_issue.sv
module stride_pf_issue #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] target,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= fire;
            if (fire) begin
                pf_addr <= target;
            end
        end
    end

endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
    import stride_pf_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int TAG_W = PC_W - IDX_W;

    logic [IDX_W-1:0]  slot_idx;
    logic [TAG_W-1:0]  slot_tag;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_prev;
    logic [ADDR_W-1:0] rd_stride;
    conf_state_e       rd_state;
    logic              hit;
    logic [ADDR_W-1:0] delta;
    logic              correct;
    conf_state_e       fsm_next;
    logic              take_new;
    logic [ADDR_W-1:0] upd_stride;
    conf_state_e       upd_state;
    logic              fire;
    logic [ADDR_W-1:0] target;

    assign slot_idx = ld_pc[IDX_W-1:0];
    assign slot_tag = ld_pc[PC_W-1:IDX_W];

    stride_pf_table #(
        .ADDR_W (ADDR_W),
        .TAG_W  (TAG_W),
        .IDX_W  (IDX_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (slot_idx),
        .wr_en     (ld_valid),
        .wr_tag    (slot_tag),
        .wr_prev   (ld_addr),
        .wr_stride (upd_stride),
        .wr_state  (upd_state),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_prev   (rd_prev),
        .rd_stride (rd_stride),
        .rd_state  (rd_state)
    );

    always_comb begin
        hit     = rd_valid && (rd_tag == slot_tag);
        delta   = ld_addr - rd_prev;
        correct = (delta == rd_stride);
    end

    stride_pf_fsm u_fsm (
        .cur_state       (rd_state),
        .correct         (correct),
        .nxt_state       (fsm_next),
        .take_new_stride (take_new)
    );

    always_comb begin
        if (!hit) begin
            upd_stride = '0;
            upd_state  = CS_INIT;
        end else begin
            upd_stride = take_new ? delta : rd_stride;
            upd_state  = fsm_next;
        end
        fire   = ld_valid && hit && (fsm_next == CS_STEADY);
        target = ld_addr + upd_stride;
    end

    stride_pf_issue #(
        .ADDR_W (ADDR_W)
    ) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .target   (target),
        .pf_valid (pf_valid),
        .pf_addr  (pf_addr)
    );

    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !hit) |=> !pf_valid); // R2

    AST_WRONG_NO_PF: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hit && !correct) |=> !pf_valid); // R6

    AST_STEADY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hit && correct && (rd_state == CS_STEADY))
        |=> (pf_valid && (pf_addr == $past(ld_addr + rd_stride)))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !pf_valid); // R11

endmodule

// File: tb/stride_prefetcher_test.sv
`timescale 1ns/1ps
module stride_prefetcher_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_valid;
    logic [31:0] ld_pc;
    logic [31:0] ld_addr;
    logic        pf_valid;
    logic [31:0] pf_addr;
    int          checks = 0;
    int          errors = 0;

    localparam logic [31:0] PC_A = 32'h0000_0101;
    localparam logic [31:0] PC_B = 32'h0000_0202;
    localparam logic [31:0] PC_C = 32'h0000_0303;
    localparam logic [31:0] PC_D = 32'h0000_1101;

    always #2 clk = ~clk;

    stride_prefetcher uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_pc    (ld_pc),
        .ld_addr  (ld_addr),
        .pf_valid (pf_valid),
        .pf_addr  (pf_addr)
    );

    task automatic expect_pf(input bit ev, input logic [31:0] ea, input string req);
        checks++;
        if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
            errors++;
            $display("FAIL %s: pf_valid=%0b pf_addr=%h expected valid=%0b addr=%h",
                     req, pf_valid, pf_addr, ev, ea);
        end
    endtask

    task automatic do_load(input logic [31:0] pc, input logic [31:0] a,
                           input bit ev, input logic [31:0] ea, input string req);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_pc    = pc;
        ld_addr  = a;
        @(posedge clk);
        #1;
        ld_valid = 1'b0;
        expect_pf(ev, ea, req);
    endtask

    task automatic idle_cycle(input string req);
        @(negedge clk);
        ld_valid = 1'b0;
        @(posedge clk);
        #1;
        expect_pf(1'b0, 32'h0, req);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; ld_valid = 1'b0; ld_pc = '0; ld_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        expect_pf(1'b0, 32'h0, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        do_load(PC_A, 32'h100, 1'b0, 32'h0, "R1 first load misses");
    endtask

    task automatic t_constant_stride;
        do_load(PC_A, 32'h110, 1'b0, 32'h0, "R4 init wrong -> transient");
        do_load(PC_A, 32'h120, 1'b1, 32'h130, "R5 R3 transient correct -> steady");
        do_load(PC_A, 32'h130, 1'b1, 32'h140, "R6 steady stays");
    endtask

    task automatic t_break_stride;
        do_load(PC_A, 32'h200, 1'b0, 32'h0, "R6 steady wrong -> init");
        do_load(PC_A, 32'h210, 1'b1, 32'h220, "R9 R4 stride kept, prev moved");
    endtask

    task automatic t_no_prediction;
        do_load(PC_B, 32'h1000, 1'b0, 32'h0, "R2 new slot");
        do_load(PC_B, 32'h1004, 1'b0, 32'h0, "R4 learn stride 4");
        do_load(PC_B, 32'h1010, 1'b0, 32'h0, "R5 transient wrong -> nopred");
        do_load(PC_B, 32'h1030, 1'b0, 32'h0, "R7 nopred wrong stays");
        do_load(PC_B, 32'h1050, 1'b0, 32'h0, "R7 nopred correct -> transient");
        do_load(PC_B, 32'h1070, 1'b1, 32'h1090, "R7 transient correct -> steady");
    endtask

    task automatic t_negative_wrap;
        do_load(PC_C, 32'h10, 1'b0, 32'h0, "R2 new slot C");
        do_load(PC_C, 32'h08, 1'b0, 32'h0, "R4 negative stride learnt");
        do_load(PC_C, 32'h00, 1'b1, 32'hFFFF_FFF8, "R8 wrap below zero");
    endtask

    task automatic t_conflict;
        do_load(PC_D, 32'h500, 1'b0, 32'h0, "R10 conflicting tag allocates");
        do_load(PC_A, 32'h220, 1'b0, 32'h0, "R10 evicted entry misses");
        do_load(PC_A, 32'h230, 1'b0, 32'h0, "R2 zero stride after realloc");
        do_load(PC_A, 32'h240, 1'b1, 32'h250, "R2 relearn to steady");
        do_load(PC_C, 32'hFFFF_FFF8, 1'b1, 32'hFFFF_FFF0, "R10 other slot intact");
    endtask

    task automatic t_idle;
        idle_cycle("R8 single-cycle pulse");
        for (int k = 0; k < 4; k++) idle_cycle("R11 idle no prefetch");
        do_load(PC_C, 32'hFFFF_FFF0, 1'b1, 32'hFFFF_FFE8, "R11 state unchanged by idle");
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_constant_stride();
        t_break_stride();
        t_no_prediction();
        t_negative_wrap();
        t_conflict();
        t_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule